// File: doc/BRIEF.md
# Bundle Decode Steering Classifier

This block sits at the front of an eight-wide decode stage. Each slot of the fetch bundle holds one 32-bit instruction word and a valid bit. A separate copy of the classifier works on each slot and decides, in the same cycle and without a register anywhere, whether the scalar decode path or the vector decode path owns the word, or whether the word must become an illegal-instruction decode. It also splits out the opcode, funct3, funct6 and funct7 fields so the two downstream decoders do not each repeat that work.

The hard case is the pair of memory opcodes that scalar floating-point and vector loads and stores have in common. There the width field, bits [14:12], picks the owner. An extension-enable mask is shared by all slots. Clearing a bit makes every instruction of that extension decode as illegal, which is useful when bringing up a part one extension at a time.

The block has no back-pressure. It is purely combinational, so every output follows its own slot's valid bit and word in the same cycle, and the consumer's stall logic is the only place where ready applies. An invalid slot carries no data, so all of its outputs are zero.

Top module: `steer_bundle`

## Requirements
- R1: For a valid slot, the opcode output equals word bits [6:0], funct3 equals bits [14:12], funct6 equals bits [31:26] and funct7 equals bits [31:25]. This holds even when the slot is flagged illegal.
- R2: When a slot's valid bit is 0, its steer, illegal, opcode, funct3, funct6 and funct7 outputs are all 0, whatever the word and the mask hold.
- R3: Opcode 0x57 (vector arithmetic) steers to the vector path (steer = 1) whenever vector enable, mask bit 4, is set. The funct3 and funct6 values have no effect on this choice.
- R4: On opcode 0x07 (FP load) or 0x27 (FP store), width values 0, 5, 6 and 7 steer to the vector path. Such words are legal only when mask bit 4 is set.
- R5: On opcode 0x07 or 0x27, width values 1, 2, 3 and 4 select scalar FP (steer = 0). Such words are legal only when scalar FP enable, mask bit 3, is set.
- R6: A valid word whose bits [1:0] are not 2'b11 is flagged illegal.
- R7: A valid word whose opcode is not in the recognised set is flagged illegal. The recognised set is 0x03, 0x07, 0x0F, 0x13, 0x17, 0x1B, 0x23, 0x27, 0x2F, 0x33, 0x37, 0x3B, 0x43, 0x47, 0x4B, 0x4F, 0x53, 0x57, 0x63, 0x67, 0x6F and 0x73.
- R8: The mask bits are: 0 base integer, 1 multiply/divide, 2 atomics (opcode 0x2F), 3 scalar FP (0x43, 0x47, 0x4B, 0x4F, 0x53, and 0x07/0x27 at scalar widths), 4 vector. A recognised instruction whose extension bit is 0 is flagged illegal. The remaining recognised opcodes belong to base integer.
- R9: On opcodes 0x33 and 0x3B, funct7 = 7'b0000001 belongs to multiply/divide (mask bit 1). Any other funct7 value belongs to base integer (mask bit 0).
- R10: An illegal slot always reports steer = 0, so the illegal decode travels on the scalar packet.
- R11: Each slot's outputs depend only on that slot's word and valid bit and on the shared mask, never on another slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| slot_word_i | input | NUM_SLOTS*32 | Instruction words; slot k is bits [32k+31:32k] |
| slot_valid_i | input | NUM_SLOTS | Per-slot valid |
| ext_en_i | input | 5 | Extension-enable mask (bit map in R8) |
| steer_vec_o | output | NUM_SLOTS | 1 = vector packet owns the slot, 0 = scalar packet |
| illegal_o | output | NUM_SLOTS | Slot decodes as an illegal instruction |
| opcode_o | output | NUM_SLOTS*7 | Extracted opcode per slot |
| funct3_o | output | NUM_SLOTS*3 | Extracted funct3 / width per slot |
| funct6_o | output | NUM_SLOTS*6 | Extracted funct6 per slot |
| funct7_o | output | NUM_SLOTS*7 | Extracted funct7 per slot |

## Verification
The assertions check a set of per-slot rules at every evaluation. An invalid slot has all outputs at zero. Illegal and vector steering never occur together. A word with bad low bits is always illegal. Vector arithmetic steers to the vector path while it is enabled, and no vector steering happens while vector enable is clear. Several behaviours can only be shown by the bench's scenarios, which compare every slot against a behavioural model: the exact split of width values on the shared memory opcodes, the funct7 split between multiply/divide and base integer, the gating by each mask bit, and the independence of slots, shown by mixing unrelated words across the bundle.

// File: rtl/steer_pkg.sv
package steer_pkg;
  localparam int WORD_W = 32;
  localparam int EXT_W  = 5;

  localparam int EXT_BASE = 0;
  localparam int EXT_MUL  = 1;
  localparam int EXT_ATOM = 2;
  localparam int EXT_FP   = 3;
  localparam int EXT_VEC  = 4;

  localparam logic [6:0] OPC_LOAD   = 7'h03;
  localparam logic [6:0] OPC_LDFP   = 7'h07;
  localparam logic [6:0] OPC_FENCE  = 7'h0F;
  localparam logic [6:0] OPC_OPIMM  = 7'h13;
  localparam logic [6:0] OPC_AUIPC  = 7'h17;
  localparam logic [6:0] OPC_OPIMMW = 7'h1B;
  localparam logic [6:0] OPC_STORE  = 7'h23;
  localparam logic [6:0] OPC_STFP   = 7'h27;
  localparam logic [6:0] OPC_AMO    = 7'h2F;
  localparam logic [6:0] OPC_OP     = 7'h33;
  localparam logic [6:0] OPC_LUI    = 7'h37;
  localparam logic [6:0] OPC_OPW    = 7'h3B;
  localparam logic [6:0] OPC_FMADD  = 7'h43;
  localparam logic [6:0] OPC_FMSUB  = 7'h47;
  localparam logic [6:0] OPC_FNMSUB = 7'h4B;
  localparam logic [6:0] OPC_FNMADD = 7'h4F;
  localparam logic [6:0] OPC_OPFP   = 7'h53;
  localparam logic [6:0] OPC_OPV    = 7'h57;
  localparam logic [6:0] OPC_BRANCH = 7'h63;
  localparam logic [6:0] OPC_JALR   = 7'h67;
  localparam logic [6:0] OPC_JAL    = 7'h6F;
  localparam logic [6:0] OPC_SYSTEM = 7'h73;

  localparam logic [6:0] F7_MULDIV  = 7'b0000001;

  typedef enum logic {PATH_SCALAR = 1'b0, PATH_VECTOR = 1'b1} path_e;

  typedef struct packed {
    logic [6:0] opcode;
    logic [2:0] funct3;
    logic [5:0] funct6;
    logic [6:0] funct7;
  } fields_t;
endpackage

// File: rtl/steer_field_split.sv
module steer_field_split
  import steer_pkg::*;
(
  input  logic              valid_i,
  input  logic [WORD_W-1:0] word_i,
  output fields_t           fields_o
);
  always_comb begin
    fields_o = '0;
    if (valid_i) begin
      fields_o.opcode = word_i[6:0];
      fields_o.funct3 = word_i[14:12];
      fields_o.funct6 = word_i[31:26];
      fields_o.funct7 = word_i[31:25];
    end
  end
endmodule

// File: rtl/steer_slot_classify.sv
module steer_slot_classify
  import steer_pkg::*;
(
  input  logic              valid_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [EXT_W-1:0]  ext_en_i,
  output path_e             path_o,
  output logic              illegal_o
);
  logic [EXT_W-1:0] owner;
  logic             vec_owner;
  logic             legal;
  logic [2:0]       width;
  logic [6:0]       f7;

  assign width = word_i[14:12];
  assign f7    = word_i[31:25];

  always_comb begin
    owner     = '0;
    vec_owner = 1'b0;
    if (word_i[1:0] == 2'b11) begin
      case (word_i[6:0])
        OPC_LOAD, OPC_FENCE, OPC_OPIMM, OPC_AUIPC, OPC_OPIMMW, OPC_STORE,
        OPC_LUI, OPC_BRANCH, OPC_JALR, OPC_JAL, OPC_SYSTEM:
          owner[EXT_BASE] = 1'b1;
        OPC_OP, OPC_OPW: begin
          if (f7 == F7_MULDIV) owner[EXT_MUL]  = 1'b1;
          else                 owner[EXT_BASE] = 1'b1;
        end
        OPC_AMO:
          owner[EXT_ATOM] = 1'b1;
        OPC_FMADD, OPC_FMSUB, OPC_FNMSUB, OPC_FNMADD, OPC_OPFP:
          owner[EXT_FP] = 1'b1;
        OPC_OPV: begin
          owner[EXT_VEC] = 1'b1;
          vec_owner      = 1'b1;
        end
        OPC_LDFP, OPC_STFP: begin
          if (width >= 3'd1 && width <= 3'd4) begin
            owner[EXT_FP] = 1'b1;
          end else begin
            owner[EXT_VEC] = 1'b1;
            vec_owner      = 1'b1;
          end
        end
        default: owner = '0;
      endcase
    end
  end

  assign legal     = |(owner & ext_en_i);
  assign illegal_o = valid_i & ~legal;
  assign path_o    = (valid_i && legal && vec_owner) ? PATH_VECTOR : PATH_SCALAR;
endmodule

// File: rtl/steer_bundle.sv
module steer_bundle
  import steer_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic [NUM_SLOTS*WORD_W-1:0] slot_word_i,
  input  logic [NUM_SLOTS-1:0]        slot_valid_i,
  input  logic [EXT_W-1:0]            ext_en_i,
  output logic [NUM_SLOTS-1:0]        steer_vec_o,
  output logic [NUM_SLOTS-1:0]        illegal_o,
  output logic [NUM_SLOTS*7-1:0]      opcode_o,
  output logic [NUM_SLOTS*3-1:0]      funct3_o,
  output logic [NUM_SLOTS*6-1:0]      funct6_o,
  output logic [NUM_SLOTS*7-1:0]      funct7_o
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [WORD_W-1:0] word;
    fields_t           fld;
    path_e             path;
    logic              ill;

    assign word = slot_word_i[s*WORD_W +: WORD_W];

    steer_field_split i_split (
      .valid_i  (slot_valid_i[s]),
      .word_i   (word),
      .fields_o (fld)
    );

    steer_slot_classify i_class (
      .valid_i   (slot_valid_i[s]),
      .word_i    (word),
      .ext_en_i  (ext_en_i),
      .path_o    (path),
      .illegal_o (ill)
    );

    assign steer_vec_o[s]      = (path == PATH_VECTOR);
    assign illegal_o[s]        = ill;
    assign opcode_o[s*7 +: 7]  = fld.opcode;
    assign funct3_o[s*3 +: 3]  = fld.funct3;
    assign funct6_o[s*6 +: 6]  = fld.funct6;
    assign funct7_o[s*7 +: 7]  = fld.funct7;

    always_comb begin
      // R2: an empty slot carries nothing
      p_invalid_zero_r2: assert (slot_valid_i[s] ||
        (path == PATH_SCALAR && !ill && fld == '0))
        else $error("R2 slot %0d not zero while invalid", s);
      // R10: illegal decodes ride the scalar packet
      p_illegal_scalar_r10: assert (!(ill && path == PATH_VECTOR))
        else $error("R10 slot %0d illegal and vector", s);
      // R6: malformed low bits are never legal
      p_lowbits_r6: assert (!(slot_valid_i[s] && word[1:0] != 2'b11) || ill)
        else $error("R6 slot %0d low bits not flagged", s);
      // R3: vector arithmetic reaches the vector path when enabled
      p_opv_vector_r3: assert (!(slot_valid_i[s] && word[6:0] == OPC_OPV &&
        ext_en_i[EXT_VEC]) || path == PATH_VECTOR)
        else $error("R3 slot %0d vector arithmetic not steered", s);
      // R8: no vector steering while vector enable is clear
      p_vec_gated_r8: assert (ext_en_i[EXT_VEC] || path == PATH_SCALAR)
        else $error("R8 slot %0d vector steer with enable clear", s);
    end
  end
endmodule

// File: tb/test_steer_bundle.sv
`timescale 1ns/1ps
module test_steer_bundle;
  localparam int NS = 8;

  logic [NS*32-1:0] slot_word_i;
  logic [NS-1:0]    slot_valid_i;
  logic [4:0]       ext_en_i;
  logic [NS-1:0]    steer_vec_o, illegal_o;
  logic [NS*7-1:0]  opcode_o, funct7_o;
  logic [NS*3-1:0]  funct3_o;
  logic [NS*6-1:0]  funct6_o;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  steer_bundle #(.NUM_SLOTS(NS)) i_steer_bundle (
    .slot_word_i, .slot_valid_i, .ext_en_i, .steer_vec_o, .illegal_o,
    .opcode_o, .funct3_o, .funct6_o, .funct7_o
  );

  // expected = {vec, ill, op7, f3, f6, f7}
  function automatic logic [24:0] model(input logic v, input logic [31:0] w,
                                        input logic [4:0] en);
    int ext;
    logic vec, ill;
    logic [6:0] op;
    if (!v) return '0;
    op = w[6:0];
    ext = -1;
    vec = 0;
    if (w[1:0] == 2'b11) begin
      if (op inside {7'h03, 7'h0F, 7'h13, 7'h17, 7'h1B, 7'h23, 7'h37,
                     7'h63, 7'h67, 7'h6F, 7'h73}) ext = 0;
      else if (op == 7'h33 || op == 7'h3B) ext = (w[31:25] == 7'd1) ? 1 : 0;
      else if (op == 7'h2F) ext = 2;
      else if (op inside {7'h43, 7'h47, 7'h4B, 7'h4F, 7'h53}) ext = 3;
      else if (op == 7'h57) begin ext = 4; vec = 1; end
      else if (op == 7'h07 || op == 7'h27) begin
        if (w[14:12] inside {3'd1, 3'd2, 3'd3, 3'd4}) ext = 3;
        else begin ext = 4; vec = 1; end
      end
    end
    ill = (ext < 0) ? 1'b1 : !en[ext];
    if (ill) vec = 0;
    return {vec, ill, op, w[14:12], w[31:26], w[31:25]};
  endfunction

  task automatic compare_all(input string tag);
    for (int s = 0; s < NS; s++) begin
      logic [24:0] exp, got;
      exp = model(slot_valid_i[s], slot_word_i[s*32 +: 32], ext_en_i);
      got = {steer_vec_o[s], illegal_o[s], opcode_o[s*7 +: 7], funct3_o[s*3 +: 3],
             funct6_o[s*6 +: 6], funct7_o[s*7 +: 7]};
      checks++;
      if (got !== exp) begin
        fails++;
        $display("FAIL %s slot %0d actual=%h expected=%h", tag, s, got, exp);
      end
    end
  endtask

  // apply on posedge, compare on the following negedge
  task automatic apply(input logic [NS*32-1:0] w, input logic [NS-1:0] v,
                       input logic [4:0] en, input string tag);
    @(posedge clk);
    slot_word_i = w; slot_valid_i = v; ext_en_i = en;
    @(negedge clk);
    compare_all(tag);
  endtask

  function automatic logic [31:0] mk(input logic [6:0] op, input logic [2:0] f3,
                                     input logic [6:0] f7);
    return {f7, 5'd9, 5'd3, f3, 5'd4, op};
  endfunction

  function automatic logic [NS*32-1:0] fill(input logic [31:0] w);
    logic [NS*32-1:0] r;
    for (int s = 0; s < NS; s++) r[s*32 +: 32] = w;
    return r;
  endfunction

  function automatic logic [31:0] rand_word();
    logic [6:0] ops [22] = '{7'h03, 7'h07, 7'h0F, 7'h13, 7'h17, 7'h1B, 7'h23,
      7'h27, 7'h2F, 7'h33, 7'h37, 7'h3B, 7'h43, 7'h47, 7'h4B, 7'h4F, 7'h53,
      7'h57, 7'h63, 7'h67, 7'h6F, 7'h73};
    logic [31:0] w;
    w = $urandom;
    if ($urandom_range(3) != 0) w[6:0] = ops[$urandom_range(21)];
    if ($urandom_range(3) == 0) w[31:25] = 7'd1;
    return w;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    slot_word_i = '0; slot_valid_i = '0; ext_en_i = '0;
    @(negedge clk);
    compare_all("R2 reset");
    // R2: invalid slots with junk words
    apply(fill(32'hFFFF_FFFF), '0, 5'h1F, "R2");
    // R1: field split, all enabled
    apply(fill(32'hA5C3_D057), '1, 5'h1F, "R1");
    // R3: vector arithmetic across funct3 groups
    for (int f = 0; f < 8; f++) apply(fill(mk(7'h57, 3'(f), 7'h55)), '1, 5'h1F, "R3");
    // R4 / R5: every width on shared load and store opcodes
    for (int f = 0; f < 8; f++) begin
      apply(fill(mk(7'h07, 3'(f), 7'h00)), '1, 5'h1F, "R4 R5 load");
      apply(fill(mk(7'h27, 3'(f), 7'h00)), '1, 5'h10, "R4 vector only");
      apply(fill(mk(7'h07, 3'(f), 7'h00)), '1, 5'h08, "R5 fp only");
    end
    // R6: low bits not 11
    apply(fill(32'h0000_4106), '1, 5'h1F, "R6");
    apply(fill(32'h0000_0001), '1, 5'h1F, "R6");
    // R7: unrecognised opcodes
    apply(fill(mk(7'h0B, 3'd0, 7'd0)), '1, 5'h1F, "R7");
    apply(fill(mk(7'h7F, 3'd0, 7'd0)), '1, 5'h1F, "R7");
    // R8: each mask bit cleared in turn
    for (int b = 0; b < 5; b++) begin
      logic [NS*32-1:0] bw;
      bw[0*32 +: 32] = mk(7'h13, 3'd0, 7'd0);
      bw[1*32 +: 32] = mk(7'h33, 3'd0, 7'd1);
      bw[2*32 +: 32] = mk(7'h2F, 3'd2, 7'd0);
      bw[3*32 +: 32] = mk(7'h53, 3'd0, 7'd0);
      bw[4*32 +: 32] = mk(7'h57, 3'd1, 7'd0);
      bw[5*32 +: 32] = mk(7'h07, 3'd6, 7'd0);
      bw[6*32 +: 32] = mk(7'h27, 3'd3, 7'd0);
      bw[7*32 +: 32] = mk(7'h63, 3'd1, 7'd0);
      apply(bw, '1, 5'h1F & ~(5'd1 << b), "R8");
    end
    // R9: funct7 split on both register-register opcodes
    apply(fill(mk(7'h33, 3'd0, 7'd1)), '1, 5'h1D, "R9");
    apply(fill(mk(7'h3B, 3'd0, 7'd1)), '1, 5'h1E, "R9");
    apply(fill(mk(7'h3B, 3'd0, 7'h20)), '1, 5'h1D, "R9");
    // R10: disabled vector word is illegal and scalar-steered
    apply(fill(mk(7'h57, 3'd3, 7'd0)), '1, 5'h0F, "R10");
    // R11: mixed bundles and partial valids
    for (int i = 0; i < 400; i++) begin
      logic [NS*32-1:0] rw;
      for (int s = 0; s < NS; s++) rw[s*32 +: 32] = rand_word();
      apply(rw, NS'($urandom), 5'($urandom), "R11");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule